// File: doc/BRIEF.md
# Dual-Host Shared Bus Arbiter

This block decides which of two hosts may drive a single internal peripheral bus: a host reached over the LPC link or a host reached over SMBus. The SMBus host talks to the arbiter through one 8-bit control word. In that word it sets a request bit, it can set a forcing bit, and it reads back a grant bit that only the arbiter drives. The SMBus host starts a peripheral cycle only after it sees the grant bit at 1. The LPC host raises `lpc_req` for as long as it wants the bus. It may proceed while `lpc_gnt` is high. While the SMBus side owns the bus, the LPC host is told to retry.

A normal SMBus request is honoured only when the bus is idle. A forced request takes the bus at once, whatever the other side is doing. If the LPC host held the bus at that moment, the arbiter fires a single-cycle abort so that the LPC front end drops its cycle. The control word returns to zero on power-on reset and also on a separate bus reset.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While either `rst_n` or `bus_rst_n` is low at a clock edge, the control word returns to 0x00 and `smb_gnt`, `lpc_gnt`, `lpc_abort` and `lpc_retry` are all 0 after that edge.
- R2: A write (`smb_wr_en` high at an edge) copies `smb_wr_data[0]` into the request bit (word bit 0) and `smb_wr_data[2]` into the forcing bit (word bit 2). The new values are readable on `smb_rd_data` after that same edge.
- R3: Word bit 1 always reads the current `smb_gnt` and cannot be changed by a write. Word bits 7:3 always read 0, even after writing 0xFF.
- R4: With the forcing bit at 0, a set request bit moves `smb_gnt` to 1 at the next edge only if `lpc_req` is low and the LPC side does not hold the bus. The grant then stays at 1 until an edge that sees the request bit at 0.
- R5: From idle, `lpc_req` high gives `lpc_gnt` = 1 at the next edge. When it arrives in the same cycle as a normal SMBus request, the LPC side wins. `lpc_gnt` drops at the first edge that sees `lpc_req` low.
- R6: With the forcing bit at 1 at an edge, `smb_gnt` is 1 and `lpc_gnt` is 0 after that edge, from any prior state.
- R7: `lpc_abort` is 1 for exactly the one cycle that follows the edge at which forced ownership is taken from an LPC owner. It stays 0 when forced ownership is taken from idle or from a normal SMBus grant.
- R8: `lpc_retry` is 1 in any cycle in which `lpc_req` is high while `smb_gnt` is 1, and 0 otherwise.
- R9: At the first edge that sees both the request and forcing bits at 0, `smb_gnt` clears. If the forcing bit is cleared while the request bit stays at 1, the grant remains at 1.
- R10: `smb_gnt` and `lpc_gnt` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| bus_rst_n | input | 1 | Synchronous active-low bus reset |
| smb_wr_en | input | 1 | SMBus-side write strobe for the control word |
| smb_wr_data | input | 8 | Write data for the control word |
| smb_rd_data | output | 8 | Control word read view (bit0 request, bit1 grant, bit2 forcing) |
| lpc_req | input | 1 | LPC host wants or is using the shared bus |
| lpc_gnt | output | 1 | LPC host owns the shared bus |
| lpc_retry | output | 1 | LPC request refused while the SMBus side owns the bus |
| lpc_abort | output | 1 | One-cycle pulse terminating an LPC cycle in flight |
| smb_gnt | output | 1 | SMBus host owns the shared bus |

## Verification
A written value appears on `smb_rd_data` one edge after the write strobe. Grant changes, the loss of `lpc_gnt` and the abort pulse appear one edge later than that, because the ownership state machine acts on the registered bits. `lpc_retry` follows `lpc_req` within the same cycle. Every stimulus step drives inputs at the falling edge and samples all outputs 2 ns after the next rising edge, so each expected value in the vector table is worked out for that single edge. Where a grant lags its register write by one step, the table holds an intermediate row that shows the register already changed and the grant not yet moved.

// File: rtl/arb_pkg.sv
// Package: shared types for the dual-host shared bus arbiter.
// Assumes: the control word layout below is decoded by the SMBus
// register front end, so the bit positions are fixed.
package arb_pkg;

    // Bit positions inside the control word (decoded by software)
    localparam int unsigned CW_REQ_BIT  = 0;
    localparam int unsigned CW_GNT_BIT  = 1;
    localparam int unsigned CW_MREQ_BIT = 2;

    // Ownership of the shared bus
    typedef enum logic [1:0] {
        OWN_IDLE  = 2'd0,
        OWN_LPC   = 2'd1,
        OWN_SMB   = 2'd2,
        OWN_FORCE = 2'd3
    } own_state_t;

endpackage

// File: rtl/arb_ctl_word.sv
// Module: arb_ctl_word
// Holds the SMBus-visible control word. Only the request and forcing
// bits are writable; the grant bit is inserted from the arbiter state
// on read, and every other bit reads as zero.
// Assumes: synchronous active-low reset; a write lands at the edge on
// which wr_en is sampled high.
module arb_ctl_word #(
    parameter int unsigned WORD_W   = 8,
    parameter int unsigned REQ_POS  = 0,
    parameter int unsigned GNT_POS  = 1,
    parameter int unsigned MREQ_POS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              gnt,
    output logic              req,
    output logic              mreq,
    output logic [WORD_W-1:0] rd_data
);

    localparam logic [WORD_W-1:0] ONE_HOT_REQ  = WORD_W'(1) << REQ_POS;
    localparam logic [WORD_W-1:0] ONE_HOT_MREQ = WORD_W'(1) << MREQ_POS;
    localparam logic [WORD_W-1:0] WR_MASK      = ONE_HOT_REQ | ONE_HOT_MREQ;

    logic [WORD_W-1:0] bits_q;

    // Store the writable bits; all other bits are masked off on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (wr_en) begin
            bits_q <= (bits_q & ~WR_MASK) | (wr_data & WR_MASK);
        end
    end

    // Build the read view: stored bits plus the live grant
    always_comb begin
        rd_data          = bits_q & WR_MASK;
        rd_data[GNT_POS] = gnt;
    end

    // Export the control bits to the ownership logic
    assign req  = bits_q[REQ_POS];
    assign mreq = bits_q[MREQ_POS];

endmodule

// File: rtl/arb_own_fsm.sv
// Module: arb_own_fsm
// Ownership state machine. A forcing request beats everything; an
// LPC request beats a normal SMBus request from idle; a normal SMBus
// request is granted only from idle.
// Assumes: req/mreq come from registers; lpc_req is synchronous.
module arb_own_fsm
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       mreq,
    input  logic       lpc_req,
    output own_state_t state,
    output logic       seize_lpc
);

    own_state_t state_q;
    own_state_t state_d;

    // Choose the next owner from the current owner and the requests
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWN_IDLE: begin
                if (mreq)         state_d = OWN_FORCE;
                else if (lpc_req) state_d = OWN_LPC;
                else if (req)     state_d = OWN_SMB;
            end
            OWN_LPC: begin
                if (mreq)          state_d = OWN_FORCE;
                else if (!lpc_req) state_d = OWN_IDLE;
            end
            OWN_SMB: begin
                if (mreq)      state_d = OWN_FORCE;
                else if (!req) state_d = OWN_IDLE;
            end
            OWN_FORCE: begin
                if (!mreq) state_d = req ? OWN_SMB : OWN_IDLE;
            end
            default: state_d = OWN_IDLE;
        endcase
    end

    // Advance the owner register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OWN_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Flag the step that takes the bus away from an LPC owner
    assign seize_lpc = (state_q == OWN_LPC) && (state_d == OWN_FORCE);
    assign state     = state_q;

endmodule

// File: rtl/arb_grant_out.sv
// Module: arb_grant_out
// Decodes the owner into grant outputs, raises retry toward a refused
// LPC request, and registers the one-cycle LPC abort.
// Assumes: seize_lpc is high only in the cycle before the owner moves
// from LPC to forced SMBus ownership.
module arb_grant_out
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  own_state_t state,
    input  logic       seize_lpc,
    input  logic       lpc_req,
    output logic       smb_gnt,
    output logic       lpc_gnt,
    output logic       lpc_retry,
    output logic       lpc_abort
);

    logic abort_q;

    // Register the abort so it lines up with the loss of lpc_gnt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort_q <= 1'b0;
        end else begin
            abort_q <= seize_lpc;
        end
    end

    // Decode the owner into grants and the retry indication
    always_comb begin
        smb_gnt   = (state == OWN_SMB) || (state == OWN_FORCE);
        lpc_gnt   = (state == OWN_LPC);
        lpc_retry = smb_gnt && lpc_req;
    end

    assign lpc_abort = abort_q;

endmodule

// File: rtl/shared_bus_arbiter.sv
// Module: shared_bus_arbiter (top)
// Arbitrates one shared peripheral bus between an LPC-side host and
// an SMBus-side host, using an SMBus-visible control word.
// Assumes: both resets are synchronous and active low; either one
// clears the whole block.
module shared_bus_arbiter
    import arb_pkg::*;
#(
    parameter int unsigned WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rst_n,
    input  logic              smb_wr_en,
    input  logic [WORD_W-1:0] smb_wr_data,
    output logic [WORD_W-1:0] smb_rd_data,
    input  logic              lpc_req,
    output logic              lpc_gnt,
    output logic              lpc_retry,
    output logic              lpc_abort,
    output logic              smb_gnt
);

    logic       rst_all_n;
    logic       req;
    logic       mreq;
    logic       seize_lpc;
    own_state_t state;

    // Either reset source clears the block
    assign rst_all_n = rst_n && bus_rst_n;

    arb_ctl_word #(
        .WORD_W  (WORD_W),
        .REQ_POS (CW_REQ_BIT),
        .GNT_POS (CW_GNT_BIT),
        .MREQ_POS(CW_MREQ_BIT)
    ) u_word (
        .clk    (clk),
        .rst_n  (rst_all_n),
        .wr_en  (smb_wr_en),
        .wr_data(smb_wr_data),
        .gnt    (smb_gnt),
        .req    (req),
        .mreq   (mreq),
        .rd_data(smb_rd_data)
    );

    arb_own_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .req      (req),
        .mreq     (mreq),
        .lpc_req  (lpc_req),
        .state    (state),
        .seize_lpc(seize_lpc)
    );

    arb_grant_out u_out (
        .clk      (clk),
        .rst_n    (rst_all_n),
        .state    (state),
        .seize_lpc(seize_lpc),
        .lpc_req  (lpc_req),
        .smb_gnt  (smb_gnt),
        .lpc_gnt  (lpc_gnt),
        .lpc_retry(lpc_retry),
        .lpc_abort(lpc_abort)
    );

endmodule

// File: rtl/arb_checker.sv
// Module: arb_checker
// Port-level properties of the shared bus arbiter, bound to the top.
// Assumes: the default word layout (request bit 0, grant bit 1,
// forcing bit 2).
module arb_checker #(
    parameter int unsigned WORD_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rst_n,
    input logic [WORD_W-1:0] smb_rd_data,
    input logic              lpc_req,
    input logic              lpc_gnt,
    input logic              lpc_retry,
    input logic              lpc_abort,
    input logic              smb_gnt
);

    logic live;
    assign live = rst_n && bus_rst_n;

    // Reset clears the word and both grants
    assert_reset_clear_R1: assert property (@(posedge clk)
        !live |=> (smb_rd_data == '0) && !smb_gnt && !lpc_gnt && !lpc_abort);

    // Grant bit mirrors the grant output; upper bits stay zero
    assert_gnt_mirror_R3: assert property (@(posedge clk) disable iff (!live)
        (smb_rd_data[1] == smb_gnt) && (smb_rd_data[WORD_W-1:3] == '0));

    // A normal grant never starts while the LPC side asks for the bus
    assert_normal_grant_R4: assert property (@(posedge clk) disable iff (!live)
        ($rose(smb_gnt) && !$past(smb_rd_data[2])) |-> !$past(lpc_req));

    // Forcing bit wins at the next edge
    assert_force_wins_R6: assert property (@(posedge clk) disable iff (!live)
        smb_rd_data[2] |=> (smb_gnt && !lpc_gnt));

    // Abort is one cycle long and only follows an LPC owner
    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (!live)
        lpc_abort |=> !lpc_abort);
    assert_abort_cause_R7: assert property (@(posedge clk) disable iff (!live)
        lpc_abort |-> ($past(lpc_gnt) && smb_gnt));

    // Retry exactly while LPC asks and SMBus owns
    assert_retry_R8: assert property (@(posedge clk) disable iff (!live)
        lpc_retry == (lpc_req && smb_gnt));

    // Both bits clear means the grant drops at the next edge
    assert_release_R9: assert property (@(posedge clk) disable iff (!live)
        (!smb_rd_data[0] && !smb_rd_data[2]) |=> !smb_gnt);

    // The two grants are exclusive
    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!live)
        !(smb_gnt && lpc_gnt));

endmodule

bind shared_bus_arbiter arb_checker #(.WORD_W(WORD_W)) u_arb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rst_n  (bus_rst_n),
    .smb_rd_data(smb_rd_data),
    .lpc_req    (lpc_req),
    .lpc_gnt    (lpc_gnt),
    .lpc_retry  (lpc_retry),
    .lpc_abort  (lpc_abort),
    .smb_gnt    (smb_gnt)
);

// File: tb/shared_bus_arbiter_bench.sv
// Bench for shared_bus_arbiter: a vector table walked one edge per
// row, then directed reset tests.
module shared_bus_arbiter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rst_n = 1'b1;
    logic       smb_wr_en = 1'b0;
    logic [7:0] smb_wr_data = 8'h00;
    logic [7:0] smb_rd_data;
    logic       lpc_req = 1'b0;
    logic       lpc_gnt;
    logic       lpc_retry;
    logic       lpc_abort;
    logic       smb_gnt;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    shared_bus_arbiter u_shared_bus_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_rst_n  (bus_rst_n),
        .smb_wr_en  (smb_wr_en),
        .smb_wr_data(smb_wr_data),
        .smb_rd_data(smb_rd_data),
        .lpc_req    (lpc_req),
        .lpc_gnt    (lpc_gnt),
        .lpc_retry  (lpc_retry),
        .lpc_abort  (lpc_abort),
        .smb_gnt    (smb_gnt)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] data;
        logic       lpc;
        logic [7:0] rd;
        logic       sg;
        logic       lg;
        logic       ab;
        logic       rt;
        logic [3:0] req;
    } vec_t;

    // One row per edge: inputs, then outputs expected 2 ns after it
    localparam vec_t TBL [26] = '{
        '{1'b1, 8'h01, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 request lands
        '{1'b0, 8'h00, 1'b0, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 granted from idle
        '{1'b0, 8'h00, 1'b1, 8'h03, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 LPC refused
        '{1'b1, 8'h00, 1'b1, 8'h02, 1'b1, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 grant held
        '{1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 release
        '{1'b0, 8'h00, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 LPC granted
        '{1'b1, 8'h01, 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 waits for LPC
        '{1'b0, 8'h00, 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 still waiting
        '{1'b1, 8'h05, 1'b1, 8'h05, 1'b0, 1'b1, 1'b0, 1'b0, 4'd2},  // R2 forcing bit lands
        '{1'b0, 8'h00, 1'b1, 8'h07, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7},  // R7 abort on seizure
        '{1'b0, 8'h00, 1'b1, 8'h07, 1'b1, 1'b0, 1'b0, 1'b1, 4'd7},  // R7 abort one cycle
        '{1'b1, 8'h01, 1'b0, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 force dropped
        '{1'b0, 8'h00, 1'b0, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 request keeps grant
        '{1'b1, 8'h04, 1'b0, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2},  // R2 force only
        '{1'b0, 8'h00, 1'b0, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0, 4'd7},  // R7 no abort from SMB
        '{1'b1, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 bits cleared
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 grant gone
        '{1'b1, 8'hFF, 1'b0, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},  // R3 ro and zero bits
        '{1'b0, 8'h00, 1'b0, 8'h07, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},  // R6 forced from idle
        '{1'b1, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b1, 8'h01, 1'b1, 8'h01, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R5 LPC wins tie
        '{1'b0, 8'h00, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0, 1'b0, 4'd5},  // R5 LPC releases
        '{1'b0, 8'h00, 1'b0, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 4'd4},  // R4 then SMB granted
        '{1'b1, 8'h00, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 4'd9}   // R10 checked each row
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one row at the falling edge, sample 2 ns after the rise
    task automatic step(input logic wr, input logic [7:0] d, input logic lpc);
        @(negedge clk);
        smb_wr_en   = wr;
        smb_wr_data = d;
        lpc_req     = lpc;
        @(posedge clk);
        #2;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            summary();
        end
    end

    initial begin
        // R1: power-on reset state
        repeat (3) @(posedge clk);
        #2;
        chk("R1 rd", smb_rd_data, 8'h00);
        chk("R1 grants", {6'd0, smb_gnt, lpc_gnt}, 8'h00);
        chk("R1 abort/retry", {6'd0, lpc_abort, lpc_retry}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        foreach (TBL[i]) begin
            step(TBL[i].wr, TBL[i].data, TBL[i].lpc);
            chk($sformatf("R%0d row%0d rd", TBL[i].req, i), smb_rd_data, TBL[i].rd);
            chk($sformatf("R%0d row%0d smb_gnt", TBL[i].req, i), {7'd0, smb_gnt}, {7'd0, TBL[i].sg});
            chk($sformatf("R%0d row%0d lpc_gnt", TBL[i].req, i), {7'd0, lpc_gnt}, {7'd0, TBL[i].lg});
            chk($sformatf("R%0d row%0d abort", TBL[i].req, i), {7'd0, lpc_abort}, {7'd0, TBL[i].ab});
            chk($sformatf("R%0d row%0d retry", TBL[i].req, i), {7'd0, lpc_retry}, {7'd0, TBL[i].rt});
            chk($sformatf("R10 row%0d exclusive", i), {7'd0, smb_gnt && lpc_gnt}, 8'h00);
        end

        // R1: bus reset clears a forced grant and the word
        step(1'b1, 8'h05, 1'b1);
        step(1'b0, 8'h00, 1'b1);
        chk("R6 forced before bus reset", {7'd0, smb_gnt}, 8'h01);
        @(negedge clk);
        bus_rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 bus reset rd", smb_rd_data, 8'h00);
        chk("R1 bus reset grants", {6'd0, smb_gnt, lpc_gnt}, 8'h00);
        chk("R1 bus reset retry", {7'd0, lpc_retry}, 8'h00);
        @(negedge clk);
        bus_rst_n = 1'b1;

        // R5: after reset, LPC request is granted at the next edge
        step(1'b0, 8'h00, 1'b1);
        chk("R5 LPC after bus reset", {7'd0, lpc_gnt}, 8'h01);

        // R1: power-on reset clears an LPC owner
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        chk("R1 por clears lpc_gnt", {7'd0, lpc_gnt}, 8'h00);
        @(negedge clk);
        rst_n   = 1'b1;
        lpc_req = 1'b0;
        @(posedge clk);

        done = 1'b1;
        summary();
    end

endmodule